// File: doc/BRIEF.md
# Chainable Event Counter Bank

This block holds a bank of general-purpose 32-bit event counters. Software can bump them through a masked increment command. Each counter takes part in an increment only when three things hold: the global run bit is set, its own enable bit is set, and its event selector holds the software-increment code. Counters are grouped into even/odd pairs. A pair can be configured as one 64-bit counter, with the even counter as the low half. When the low half wraps, the carry moves into the high half, and the overflow is reported on the high half instead of the low one.

One register-style write port sets every piece of state. It loads a counter value, an event selector, a chain bit, the enable mask or the global run bit. A combinational read port returns any counter. The sticky overflow flags are always visible on an output and are cleared by a write-one-to-clear mask. The bank has no streaming data path, so there is no valid/ready handshake and no back-pressure. An increment command is accepted in every cycle that `inc_valid` is high, and all of its effects land on the next rising clock edge.

Top module: `ecb_bank`

## Requirements
- R1: An increment command has no effect when its mask is all zero. Mask bits at index NUM_CTR (6) and above, which include index 31 (reserved for a cycle counter), are ignored.
- R2: While the global run bit is 0, an increment command changes no counter and no flag.
- R3: A counter responds to its mask bit only if both of these hold:
  - its enable bit is 1;
  - its 10-bit event selector equals 0x000.
  Any other selector value, or a clear enable bit, leaves that counter unchanged.
- R4: Each selected counter adds one, modulo 2^32. A counter that does not wrap changes nothing else.
- R5: When a counter of an unchained pair wraps from 0xFFFFFFFF to 0, its own overflow flag (bit i of `ovf_flags`) is set.
- R6: A pair (0,1), (2,3) or (4,5) is chained when the chain bit of its odd member is 1. When the low counter of a chained pair wraps, the high counter adds one, modulo 2^32. The low flag is not set. The high flag is set only if the high counter also wraps to 0.
- R7: If a high counter receives a carry and is selected itself in the same command, it advances by two. Its flag is set if it passes through zero.
- R8: Overflow flags are sticky. A flag clears only when the matching `ovf_clr` bit is 1. If a set and a clear hit the same flag in the same cycle, the set wins.
- R9: A counter-value write and an increment in the same cycle: the write wins for that counter. That counter's own increment, its carry and its flag for that cycle are dropped.
- R10: Write targets (`wr_tgt`) are encoded as follows:
  - 0: counter value, from `wr_data`;
  - 1: event selector, from `wr_data[9:0]`;
  - 2: chain bit, from `wr_data[0]`; ignored when `wr_idx` is even;
  - 3: enable mask, from `wr_data[5:0]`;
  - 4: global run bit, from `wr_data[0]`.
  An increment in the same cycle as a configuration write uses the values held before that write.
- R11: After reset, every counter, selector, enable bit, chain bit, flag and the run bit are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_tgt | input | 3 | Write target code (R10) |
| wr_idx | input | 3 | Counter index for the write |
| wr_data | input | 32 | Write data |
| inc_valid | input | 1 | Software-increment command strobe |
| inc_mask | input | 32 | Per-counter increment mask |
| ovf_clr | input | 6 | Write-one-to-clear mask for the overflow flags |
| rd_idx | input | 3 | Counter index to read |
| rd_cnt | output | 32 | Value of the selected counter (0 when out of range) |
| ovf_flags | output | 6 | Sticky overflow flags, one per counter |

## Verification
The bound checker watches these properties on every cycle:
- flags are sticky;
- no flag appears without an increment command;
- counters hold still when the mask is empty or the run bit is low;
- the low member of a chained pair never raises a flag.

The exact arithmetic is left to the bench's scenarios:
- the carry into the high half;
- the double step of a high counter;
- gating by selector and enable;
- the write-over-increment priority;
- the set-wins-over-clear rule;
- the use of pre-write configuration.

// File: rtl/ecb_pkg.sv
package ecb_pkg;
  typedef enum logic [2:0] {
    TGT_CNT   = 3'd0,
    TGT_EVT   = 3'd1,
    TGT_CHAIN = 3'd2,
    TGT_ENA   = 3'd3,
    TGT_GLB   = 3'd4
  } wr_tgt_e;
endpackage

// File: rtl/ecb_inc_select.sv
module ecb_inc_select #(
  parameter int NUM_CTR = 6,
  parameter int EVT_W   = 10,
  parameter logic [EVT_W-1:0] SWINC_CODE = '0
) (
  input  logic                            inc_valid,
  input  logic                            glb,
  input  logic [NUM_CTR-1:0]              mask,
  input  logic [NUM_CTR-1:0]              ena,
  input  logic [NUM_CTR-1:0]              block,
  input  logic [NUM_CTR-1:0][EVT_W-1:0]   evt,
  output logic [NUM_CTR-1:0]              sel
);
  // A counter steps only when the command, run bit, its enable and its
  // event code all agree, and no value write targets it this cycle.
  for (genvar i = 0; i < NUM_CTR; i++) begin : g_sel
    assign sel[i] = inc_valid & glb & mask[i] & ena[i] & ~block[i]
                    & (evt[i] == SWINC_CODE);
  end
endmodule

// File: rtl/ecb_pair_adder.sv
module ecb_pair_adder #(
  parameter int CTR_W = 32
) (
  input  logic [CTR_W-1:0] lo,
  input  logic [CTR_W-1:0] hi,
  input  logic             sel_lo,
  input  logic             sel_hi,
  input  logic             chain,
  output logic [CTR_W-1:0] lo_nxt,
  output logic [CTR_W-1:0] hi_nxt,
  output logic             ovf_lo,
  output logic             ovf_hi
);
  logic [CTR_W:0] lo_sum;
  logic [CTR_W:0] hi_sum;
  logic           carry;

  always_comb begin
    lo_sum = {1'b0, lo} + (CTR_W+1)'(sel_lo);
    carry  = lo_sum[CTR_W] & chain;
    // high half may take its own step plus the carry: up to +2
    hi_sum = {1'b0, hi} + (CTR_W+1)'(sel_hi) + (CTR_W+1)'(carry);
    lo_nxt = lo_sum[CTR_W-1:0];
    hi_nxt = hi_sum[CTR_W-1:0];
    ovf_lo = lo_sum[CTR_W] & ~chain;
    ovf_hi = hi_sum[CTR_W];
  end
endmodule

// File: rtl/ecb_bank.sv
module ecb_bank #(
  parameter int NUM_CTR = 6,
  parameter int CTR_W   = 32,
  parameter int EVT_W   = 10,
  parameter int MASK_W  = 32,
  parameter logic [EVT_W-1:0] SWINC_CODE = '0,
  localparam int IDX_W  = $clog2(NUM_CTR)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [2:0]           wr_tgt,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [CTR_W-1:0]     wr_data,
  input  logic                 inc_valid,
  input  logic [MASK_W-1:0]    inc_mask,
  input  logic [NUM_CTR-1:0]   ovf_clr,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic [CTR_W-1:0]     rd_cnt,
  output logic [NUM_CTR-1:0]   ovf_flags
);
  import ecb_pkg::*;

  localparam int NUM_PAIRS = NUM_CTR / 2;

  logic [NUM_CTR-1:0][CTR_W-1:0] cnt_q, cnt_d;
  logic [NUM_CTR-1:0][EVT_W-1:0] evt_q;
  logic [NUM_CTR-1:0]            ena_q, ovf_q, ovf_set, cnt_hit, sel;
  logic [NUM_PAIRS-1:0]          pair_chain_q;
  logic                          glb_q;
  logic                          idx_ok;
  wr_tgt_e                       tgt;
  logic                          unused_mask_hi;

  assign tgt            = wr_tgt_e'(wr_tgt);
  assign idx_ok         = int'(wr_idx) < NUM_CTR;
  assign unused_mask_hi = ^inc_mask[MASK_W-1:NUM_CTR];

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_hit
    assign cnt_hit[i] = wr_en && (tgt == TGT_CNT) && (wr_idx == IDX_W'(i));
  end

  ecb_inc_select #(
    .NUM_CTR(NUM_CTR), .EVT_W(EVT_W), .SWINC_CODE(SWINC_CODE)
  ) u_sel (
    .inc_valid(inc_valid),
    .glb      (glb_q),
    .mask     (inc_mask[NUM_CTR-1:0]),
    .ena      (ena_q),
    .block    (cnt_hit),
    .evt      (evt_q),
    .sel      (sel)
  );

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    ecb_pair_adder #(.CTR_W(CTR_W)) u_pair (
      .lo    (cnt_q[2*p]),
      .hi    (cnt_q[2*p+1]),
      .sel_lo(sel[2*p]),
      .sel_hi(sel[2*p+1]),
      .chain (pair_chain_q[p]),
      .lo_nxt(cnt_d[2*p]),
      .hi_nxt(cnt_d[2*p+1]),
      .ovf_lo(ovf_set[2*p]),
      .ovf_hi(ovf_set[2*p+1])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q        <= '0;
      evt_q        <= '0;
      ena_q        <= '0;
      ovf_q        <= '0;
      pair_chain_q <= '0;
      glb_q        <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_CTR; i++) begin
        cnt_q[i] <= cnt_hit[i] ? wr_data : cnt_d[i];
      end
      // a written counter drops its own flag event this cycle
      ovf_q <= (ovf_q & ~ovf_clr) | (ovf_set & ~cnt_hit);
      if (wr_en) begin
        unique case (tgt)
          TGT_EVT:   if (idx_ok) evt_q[wr_idx] <= wr_data[EVT_W-1:0];
          TGT_CHAIN: if (idx_ok && wr_idx[0])
                       pair_chain_q[wr_idx[IDX_W-1:1]] <= wr_data[0];
          TGT_ENA:   ena_q <= wr_data[NUM_CTR-1:0];
          TGT_GLB:   glb_q <= wr_data[0];
          default:   ;
        endcase
      end
    end
  end

  assign rd_cnt    = (int'(rd_idx) < NUM_CTR) ? cnt_q[rd_idx] : '0;
  assign ovf_flags = ovf_q;
endmodule

// File: rtl/ecb_bank_chk.sv
module ecb_bank_chk #(
  parameter int NUM_CTR = 6,
  parameter int CTR_W   = 32,
  parameter int MASK_W  = 32,
  localparam int NUM_PAIRS = NUM_CTR / 2
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          wr_en,
  input logic                          inc_valid,
  input logic [MASK_W-1:0]             inc_mask,
  input logic [NUM_CTR-1:0]            ovf_clr,
  input logic [NUM_CTR-1:0]            ovf_flags,
  input logic                          glb_q,
  input logic [NUM_PAIRS-1:0]          pair_chain_q,
  input logic [NUM_CTR-1:0][CTR_W-1:0] cnt_q
);
  // R1: empty (in-range) mask leaves counters and flags alone
  assert_empty_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
    inc_valid && (inc_mask[NUM_CTR-1:0] == '0) && !wr_en
    |=> $stable(cnt_q) && ((ovf_flags & ~$past(ovf_flags)) == '0));

  // R2: run bit low blocks every counter update
  assert_glb_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    inc_valid && !glb_q && !wr_en |=> $stable(cnt_q));

  // R8: a flag only falls where a clear bit was given
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(ovf_flags) & ~ovf_flags & ~$past(ovf_clr)) == '0));

  // R8: flags only rise on an increment command
  assert_no_spont_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !inc_valid |=> ((ovf_flags & ~$past(ovf_flags)) == '0));

  // R6: the low half of a chained pair never raises its own flag
  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_chain
    assert_low_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pair_chain_q[p] && !wr_en |=> !$rose(ovf_flags[2*p]));
  end
endmodule

bind ecb_bank ecb_bank_chk #(
  .NUM_CTR(NUM_CTR), .CTR_W(CTR_W), .MASK_W(MASK_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .inc_valid   (inc_valid),
  .inc_mask    (inc_mask),
  .ovf_clr     (ovf_clr),
  .ovf_flags   (ovf_flags),
  .glb_q       (glb_q),
  .pair_chain_q(pair_chain_q),
  .cnt_q       (cnt_q)
);

// File: tb/ecb_bank_tb.sv
module ecb_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_tgt = '0;
  logic [2:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic        inc_valid = 1'b0;
  logic [31:0] inc_mask = '0;
  logic [5:0]  ovf_clr = '0;
  logic [2:0]  rd_idx = '0;
  logic [31:0] rd_cnt;
  logic [5:0]  ovf_flags;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    int          idx;   // -1 selects the flag vector
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t q[$];
  event  item_ev;

  always #4 clk = ~clk;  // 125 MHz

  ecb_bank u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_tgt(wr_tgt),
    .wr_idx(wr_idx), .wr_data(wr_data), .inc_valid(inc_valid),
    .inc_mask(inc_mask), .ovf_clr(ovf_clr), .rd_idx(rd_idx),
    .rd_cnt(rd_cnt), .ovf_flags(ovf_flags)
  );

  // monitor: pops expected items and compares with the outputs
  initial begin
    forever begin
      @(item_ev);
      #1;
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it  = q.pop_front();
        act = (it.idx < 0) ? {26'b0, ovf_flags} : rd_cnt;
        n_tests++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s idx=%0d actual=%h expected=%h", it.req, it.idx, act, it.exp);
        end
      end
    end
  end

  task automatic op(bit we, logic [2:0] tgt, int idx, logic [31:0] data,
                    bit iv, logic [31:0] mask, logic [5:0] clr);
    @(negedge clk);
    wr_en = we; wr_tgt = tgt; wr_idx = idx[2:0]; wr_data = data;
    inc_valid = iv; inc_mask = mask; ovf_clr = clr;
    @(negedge clk);
    wr_en = 1'b0; inc_valid = 1'b0; inc_mask = '0; ovf_clr = '0;
  endtask

  task automatic wreg(logic [2:0] tgt, int idx, logic [31:0] data);
    op(1'b1, tgt, idx, data, 1'b0, '0, '0);
  endtask
  task automatic inc(logic [31:0] mask);
    op(1'b0, 3'd0, 0, '0, 1'b1, mask, '0);
  endtask
  task automatic clr_all();
    op(1'b0, 3'd0, 0, '0, 1'b0, '0, 6'h3F);
  endtask

  task automatic exp_cnt(int idx, logic [31:0] exp, string req);
    item_t it;
    rd_idx = idx[2:0];
    it.idx = idx; it.exp = exp; it.req = req;
    q.push_back(it);
    -> item_ev;
    #2;
  endtask
  task automatic exp_flags(logic [5:0] exp, string req);
    item_t it;
    it.idx = -1; it.exp = {26'b0, exp}; it.req = req;
    q.push_back(it);
    -> item_ev;
    #2;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    exp_cnt(0, 32'h0, "R11");
    exp_flags(6'h00, "R11");

    wreg(3'd4, 0, 32'h1);
    wreg(3'd3, 0, 32'h3F);
    wreg(3'd0, 0, 32'd5);
    inc(32'h1);
    exp_cnt(0, 32'd6, "R4");
    exp_cnt(1, 32'd0, "R4");

    inc(32'h0);
    exp_cnt(0, 32'd6, "R1");
    inc(32'h8000_0040);
    exp_cnt(0, 32'd6, "R1");
    exp_cnt(5, 32'd0, "R1");
    exp_flags(6'h00, "R1");

    wreg(3'd4, 0, 32'h0);
    inc(32'h1);
    exp_cnt(0, 32'd6, "R2");
    wreg(3'd4, 0, 32'h1);

    wreg(3'd1, 2, 32'h011);
    inc(32'h4);
    exp_cnt(2, 32'd0, "R3");
    wreg(3'd3, 0, 32'h37);
    inc(32'h8);
    exp_cnt(3, 32'd0, "R3");
    wreg(3'd1, 2, 32'h000);
    wreg(3'd3, 0, 32'h3F);
    inc(32'hC);
    exp_cnt(2, 32'd1, "R3");
    exp_cnt(3, 32'd1, "R3");

    wreg(3'd0, 4, 32'hFFFF_FFFF);
    inc(32'h10);
    exp_cnt(4, 32'd0, "R5");
    exp_flags(6'h10, "R5");
    exp_cnt(5, 32'd0, "R5");

    inc(32'h1);
    exp_cnt(0, 32'd7, "R4");
    exp_flags(6'h10, "R8");
    op(1'b0, 3'd0, 0, '0, 1'b0, '0, 6'h10);
    exp_flags(6'h00, "R8");

    wreg(3'd2, 1, 32'h1);
    wreg(3'd0, 0, 32'hFFFF_FFFF);
    wreg(3'd0, 1, 32'd7);
    inc(32'h1);
    exp_cnt(0, 32'd0, "R6");
    exp_cnt(1, 32'd8, "R6");
    exp_flags(6'h00, "R6");
    wreg(3'd0, 0, 32'hFFFF_FFFF);
    wreg(3'd0, 1, 32'hFFFF_FFFF);
    inc(32'h1);
    exp_cnt(1, 32'd0, "R6");
    exp_flags(6'h02, "R6");
    clr_all();

    wreg(3'd2, 2, 32'h1);  // even index: ignored
    wreg(3'd0, 2, 32'hFFFF_FFFF);
    inc(32'h4);
    exp_cnt(2, 32'd0, "R10");
    exp_cnt(3, 32'd1, "R10");
    exp_flags(6'h04, "R10");
    clr_all();

    wreg(3'd0, 0, 32'hFFFF_FFFF);
    wreg(3'd0, 1, 32'hFFFF_FFFF);
    inc(32'h3);
    exp_cnt(0, 32'd0, "R7");
    exp_cnt(1, 32'd1, "R7");
    exp_flags(6'h02, "R7");
    clr_all();

    wreg(3'd0, 0, 32'hFFFF_FFFF);
    wreg(3'd0, 1, 32'd5);
    op(1'b1, 3'd0, 0, 32'h20, 1'b1, 32'h1, '0);
    exp_cnt(0, 32'h20, "R9");
    exp_cnt(1, 32'd5, "R9");
    wreg(3'd0, 0, 32'hFFFF_FFFF);
    wreg(3'd0, 1, 32'hFFFF_FFFF);
    op(1'b1, 3'd0, 1, 32'd9, 1'b1, 32'h1, '0);
    exp_cnt(0, 32'd0, "R9");
    exp_cnt(1, 32'd9, "R9");
    exp_flags(6'h00, "R9");

    wreg(3'd0, 4, 32'hFFFF_FFFF);
    op(1'b0, 3'd0, 0, '0, 1'b1, 32'h10, 6'h10);
    exp_flags(6'h10, "R8");
    clr_all();

    wreg(3'd0, 0, 32'd0);
    op(1'b1, 3'd4, 0, 32'h0, 1'b1, 32'h1, '0);
    exp_cnt(0, 32'd1, "R10");
    inc(32'h1);
    exp_cnt(0, 32'd1, "R2");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule